// File: doc/BRIEF.md
# Hot-Plug Detect Filter and Interrupt Bank

This block cleans up two slow, bouncy link-status inputs: the hot-plug-detect line and the receiver-sense line of a display transmitter. Each input first passes through a two-flop synchroniser. It then passes through two reject stages in series. The first is a fine stage that throws away any change lasting N cycles or fewer. The second is a coarse stage that throws away any level lasting M*1024 cycles or fewer. Software reads the two filtered levels from a status word.

Each filtered level has a rising-edge bit and a falling-edge bit in a sticky status vector. A rising edge on a core interrupt input sets one more bit. Software can also set any status bit by writing ones, and clears bits through a separate write-one-to-clear register. An active-high enable mask then folds the status bits into a single interrupt line.

The register port is a simple single-cycle write strobe with a combinational read. It uses byte offsets that a driver decodes.

Top module: `hpd_sense_filter`

## Requirements
- R1: Each raw input passes through a two-flop synchroniser and then a fine stage. In the fine stage, a changed level held for N or fewer consecutive cycles is dropped, and one held for N+1 cycles passes. N is bits 15:12 of the filter register at byte offset 0x08.
- R2: A coarse stage follows the fine stage. It drops a level held for M*1024 or fewer cycles, where M is bits 11:0 of the filter register. A pulse of W cycles therefore reaches the output only if W > max(N, M*1024).
- R3: The filtered levels read at offset 0x38: bit 0 is hot-plug detect and bit 1 is receiver sense. A new raw value first sampled at a clock edge shows there after N+M*1024+3 further edges.
- R4: One cycle after a filtered level changes, its edge bit sets in the status register at offset 0x10. The bits are: 1 for a hot-plug rise, 2 for a hot-plug fall, 6 for a receiver-sense rise and 7 for a receiver-sense fall. The bits stay set until cleared.
- R5: A rising edge on core_irq_i sets status bit 0 on the clock edge that first samples the high value.
- R6: Writing to offset 0x10 sets every status bit written as 1 and leaves bits written as 0 unchanged. Only bits 0, 1, 2, 6 and 7 exist; all other bits read 0.
- R7: Writing 1s to offset 0x14 clears those status bits. If a hardware edge sets the same bit in the same cycle, the bit stays set.
- R8: The mask register at offset 0x0C enables a source with a 1. irq_o is the OR of status AND mask, with no register delay.
- R9: After reset, the filter register, mask, status, filtered levels and irq_o are all 0.
- R10: The filter register reads back its 16 bits, and the mask reads back its implemented bits. Offset 0x14 and any unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hpd_raw_i | input | 1 | Raw hot-plug-detect pin, asynchronous |
| rxsense_raw_i | input | 1 | Raw receiver-sense pin, asynchronous |
| core_irq_i | input | 1 | Core interrupt request, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_o | output | 1 | Masked interrupt output |

## Verification
The assertions take a few things for granted:
- core_irq_i and the register strobe, address and data are already synchronous to clk. Only the two raw pins may change at any time.
- Software does not rewrite the filter register while a level change is being counted.

The stimulus keeps to this. It drives every input on the falling clock edge, and it reprograms the filter only after both raw inputs have been held steady for longer than the whole filter delay. Random pulse widths cluster around the N and M*1024 thresholds, so that both rejected and accepted pulses occur.

// File: rtl/hpdf_pkg.sv
// Package: register offsets, status bit positions and filter field layout
// shared by the hot-plug filter block and its bench.
package hpdf_pkg;
    localparam int STAT_W     = 8;
    localparam int GLITCH_W   = 4;   // fine reject field width
    localparam int VALID_W    = 12;  // coarse reject field width
    localparam int FILT_W     = GLITCH_W + VALID_W;
    localparam int N_CH       = 2;   // channel 0 hot-plug, 1 receiver sense

    localparam logic [7:0] OFS_FILTER = 8'h08;
    localparam logic [7:0] OFS_MASK   = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_CLEAR  = 8'h14;
    localparam logic [7:0] OFS_LEVEL  = 8'h38;

    localparam int BIT_CORE     = 0;
    localparam int BIT_HPD_RISE = 1;
    localparam int BIT_HPD_FALL = 2;
    localparam int BIT_RX_RISE  = 6;
    localparam int BIT_RX_FALL  = 7;

    localparam logic [STAT_W-1:0] IMPL_MASK = 8'hC7;

    typedef struct packed {
        logic [GLITCH_W-1:0] glitch;  // bits 15:12
        logic [VALID_W-1:0]  valid;   // bits 11:0
    } filt_cfg_t;
endpackage

// File: rtl/hpdf_sync.sv
// Multi-stage flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module hpdf_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the raw value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage copies its predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpdf_hold_stage.sv
// Hold-time reject stage: the output takes a new input level only after
// the input has differed from it for limit_i+1 consecutive cycles.
// Assumes limit_i is stable while a change is being counted.
module hpdf_hold_stage #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             level_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count cycles of disagreement; flip once the limit is passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= 1'b0;
            cnt_q   <= '0;
        end else if (din_i == level_o) begin
            cnt_q   <= '0;
        end else if (cnt_q >= limit_i) begin
            level_o <= din_i;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R1
    hold_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> $past(din_i != level_o));
endmodule

// File: rtl/hpdf_filter.sv
// Two-stage level filter for one synchronised input: a fine reject of up
// to N cycles followed by a coarse reject in units of 2**UNIT_LOG2 cycles.
module hpdf_filter #(
    parameter int GW        = 4,
    parameter int VW        = 12,
    parameter int UNIT_LOG2 = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic [GW-1:0] glitch_i,
    input  logic [VW-1:0] valid_i,
    output logic          level_o
);
    localparam int LW = VW + UNIT_LOG2;

    logic          fine_lvl;
    logic [LW-1:0] coarse_limit;

    assign coarse_limit = {valid_i, {UNIT_LOG2{1'b0}}};

    hpdf_hold_stage #(.CNT_W(GW)) u_fine (
        .clk(clk), .rst_n(rst_n), .din_i(sync_i),
        .limit_i(glitch_i), .level_o(fine_lvl));

    hpdf_hold_stage #(.CNT_W(LW)) u_coarse (
        .clk(clk), .rst_n(rst_n), .din_i(fine_lvl),
        .limit_i(coarse_limit), .level_o(level_o));

    // R2
    coarse_follows_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> $past(fine_lvl) == level_o);
endmodule

// File: rtl/hpdf_irq_bank.sv
// Sticky interrupt status with edge capture, software set, W1C clear and
// an enable mask. Assumes set/clear strobes are one-cycle and synchronous.
module hpdf_irq_bank
    import hpdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   level_i,
    input  logic              core_i,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    input  logic [STAT_W-1:0] mask_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic [N_CH-1:0]   level_q;
    logic              core_q;
    logic [STAT_W-1:0] hw_set;

    // Remember the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            core_q  <= 1'b0;
        end else begin
            level_q <= level_i;
            core_q  <= core_i;
        end
    end

    // Map detected edges onto their status positions.
    always_comb begin
        hw_set               = '0;
        hw_set[BIT_CORE]     = core_i & ~core_q;
        hw_set[BIT_HPD_RISE] = level_i[0] & ~level_q[0];
        hw_set[BIT_HPD_FALL] = ~level_i[0] & level_q[0];
        hw_set[BIT_RX_RISE]  = level_i[1] & ~level_q[1];
        hw_set[BIT_RX_FALL]  = ~level_i[1] & level_q[1];
    end

    // Sticky status: clear first, then sets override.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= ((status_o & ~clr_i) | hw_set | set_i) & IMPL_MASK;
    end

    assign irq_o = |(status_o & mask_i);

    // R4
    hpd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_i[0]) |=> status_o[BIT_HPD_RISE]);
    // R4
    rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_i[1]) |=> status_o[BIT_RX_FALL]);
    // R5
    core_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_i) |=> status_o[BIT_CORE]);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set & clr_i) != '0 |=>
        (status_o & $past(hw_set & clr_i)) == $past(hw_set & clr_i));
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i & ~hw_set & ~set_i) != '0 |=>
        (status_o & $past(clr_i & ~hw_set & ~set_i)) == '0);
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i == '0 |-> !irq_o);
endmodule

// File: rtl/hpd_sense_filter.sv
// Top: synchronises and filters the hot-plug and receiver-sense pins,
// captures edges into a sticky interrupt bank and exposes a register port.
// Assumes reg_* and core_irq_i are synchronous to clk.
module hpd_sense_filter
    import hpdf_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int UNIT_LOG2   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hpd_raw_i,
    input  logic              rxsense_raw_i,
    input  logic              core_irq_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    filt_cfg_t         filt_q;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [N_CH-1:0]   raw_vec;
    logic [N_CH-1:0]   sync_vec;
    logic [N_CH-1:0]   lvl_vec;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:FILT_W];
    assign raw_vec      = {rxsense_raw_i, hpd_raw_i};

    hpdf_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_vec), .sync_o(sync_vec));

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        hpdf_filter #(.GW(GLITCH_W), .VW(VALID_W), .UNIT_LOG2(UNIT_LOG2)) u_filt (
            .clk(clk), .rst_n(rst_n), .sync_i(sync_vec[c]),
            .glitch_i(filt_q.glitch), .valid_i(filt_q.valid),
            .level_o(lvl_vec[c]));
    end

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= '0;
            mask_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == ADDR_W'(OFS_FILTER)) filt_q <= reg_wdata_i[FILT_W-1:0];
            if (reg_addr_i == ADDR_W'(OFS_MASK))   mask_q <= reg_wdata_i[STAT_W-1:0] & IMPL_MASK;
        end
    end

    // One-cycle set and clear strobes for the status bank.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (reg_wr_i && reg_addr_i == ADDR_W'(OFS_STATUS)) set_vec = reg_wdata_i[STAT_W-1:0];
        if (reg_wr_i && reg_addr_i == ADDR_W'(OFS_CLEAR))  clr_vec = reg_wdata_i[STAT_W-1:0];
    end

    hpdf_irq_bank u_bank (
        .clk(clk), .rst_n(rst_n), .level_i(lvl_vec), .core_i(core_irq_i),
        .set_i(set_vec), .clr_i(clr_vec), .mask_i(mask_q),
        .status_o(status), .irq_o(irq_o));

    // Combinational read mux.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_W'(OFS_FILTER): reg_rdata_o[FILT_W-1:0] = filt_q;
            ADDR_W'(OFS_MASK):   reg_rdata_o[STAT_W-1:0] = mask_q;
            ADDR_W'(OFS_STATUS): reg_rdata_o[STAT_W-1:0] = status;
            ADDR_W'(OFS_LEVEL):  reg_rdata_o[N_CH-1:0]   = lvl_vec;
            default:             reg_rdata_o = '0;
        endcase
    end

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i != ADDR_W'(OFS_FILTER) && reg_addr_i != ADDR_W'(OFS_MASK) &&
         reg_addr_i != ADDR_W'(OFS_STATUS) && reg_addr_i != ADDR_W'(OFS_LEVEL))
        |-> reg_rdata_o == '0);
    // R6
    status_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i && reg_addr_i == ADDR_W'(OFS_STATUS) |=>
        ((status & $past(reg_wdata_i[STAT_W-1:0])) & IMPL_MASK)
        == ($past(reg_wdata_i[STAT_W-1:0]) & IMPL_MASK));
endmodule

// File: tb/hpd_sense_filter_bench.sv
module hpd_sense_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hpd_raw = 1'b0, rx_raw = 1'b0, core_irq = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    localparam logic [7:0] A_FILT = 8'h08, A_MASK = 8'h0C, A_STAT = 8'h10,
                           A_CLR = 8'h14, A_LVL = 8'h38;

    always #2 clk = ~clk;

    hpd_sense_filter u_hpd_sense_filter (
        .clk(clk), .rst_n(rst_n), .hpd_raw_i(hpd_raw), .rxsense_raw_i(rx_raw),
        .core_irq_i(core_irq), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

    function automatic bit accepted(int w, int n, int m);
        int lim = (m * 1024 > n) ? m * 1024 : n;
        return w > lim;
    endfunction

    function automatic logic [7:0] edge_bits(int ch);
        return (ch == 0) ? 8'h06 : 8'hC0;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_raw(input int ch, input logic v);
        if (ch == 0) hpd_raw = v; else rx_raw = v;
    endtask

    initial begin
        logic [31:0] rd;
        logic [7:0]  exp_stat;
        void'($urandom(32'd20240819));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        reg_read(A_FILT, rd); check(rd, 0, "R9 filter");
        reg_read(A_MASK, rd); check(rd, 0, "R9 mask");
        reg_read(A_STAT, rd); check(rd, 0, "R9 status");
        reg_read(A_LVL, rd);  check(rd, 0, "R9 level");
        check({31'b0, irq}, 0, "R9 irq");
        // R10 readback and unmapped
        reg_write(A_FILT, 32'hFFFF_A0A0); reg_read(A_FILT, rd); check(rd, 32'h0000_A0A0, "R10 filter");
        reg_write(A_MASK, 32'hFF);        reg_read(A_MASK, rd); check(rd, 32'hC7, "R10 mask");
        reg_read(A_CLR, rd);  check(rd, 0, "R10 clear reads 0");
        reg_read(8'h04, rd);  check(rd, 0, "R10 unmapped");

        // R3 latency, N=10 M=0, hot-plug rise
        reg_write(A_FILT, {16'h0, 4'd10, 12'd0});
        reg_write(A_MASK, 32'h02);
        hpd_raw = 1'b1;
        repeat (13) @(posedge clk);
        @(negedge clk); reg_read(A_LVL, rd); check(rd, 0, "R3 level before");
        @(posedge clk); @(negedge clk);
        reg_read(A_LVL, rd); check(rd, 1, "R3 level at");
        reg_read(A_STAT, rd); check(rd, 0, "R4 status not yet");
        @(posedge clk); @(negedge clk);
        reg_read(A_STAT, rd); check(rd, 32'h02, "R4 hpd rise");
        check({31'b0, irq}, 1, "R8 irq enabled");
        reg_write(A_MASK, 32'h04);
        check({31'b0, irq}, 0, "R8 irq masked");
        hpd_raw = 1'b0;
        repeat (30) @(negedge clk);
        reg_read(A_STAT, rd); check(rd, 32'h06, "R4 hpd fall sticky");
        check({31'b0, irq}, 1, "R8 irq fall");
        reg_write(A_CLR, 32'hFF);
        reg_read(A_STAT, rd); check(rd, 0, "R7 clear all");

        // R2/R3 coarse latency, N=3 M=1, receiver sense
        reg_write(A_FILT, {16'h0, 4'd3, 12'd1});
        rx_raw = 1'b1;
        repeat (3 + 3 + 1024) @(posedge clk);
        @(negedge clk); reg_read(A_LVL, rd); check(rd, 0, "R2 coarse before");
        @(posedge clk); @(negedge clk);
        reg_read(A_LVL, rd); check(rd, 2, "R2 coarse at");
        rx_raw = 1'b0;
        repeat (1040) @(negedge clk);
        reg_write(A_CLR, 32'hFF);

        // R1/R2 random pulses around the thresholds
        for (int t = 0; t < 30; t++) begin
            int ch = $urandom % 2;
            int n  = $urandom % 16;
            int m  = (t % 6 == 5) ? 1 : 0;
            int w  = (m == 1) ? 1020 + ($urandom % 11) : 1 + ($urandom % 20);
            logic [7:0] msk = $urandom;
            reg_write(A_FILT, {16'h0, n[3:0], m[11:0]});
            reg_write(A_CLR, 32'hFF);
            set_raw(ch, 1'b1);
            repeat (w) @(negedge clk);
            set_raw(ch, 1'b0);
            repeat (n + m * 1024 + 12) @(negedge clk);
            exp_stat = accepted(w, n, m) ? edge_bits(ch) : 8'h00;
            reg_read(A_STAT, rd);
            check(rd, {24'h0, exp_stat}, (m == 1) ? "R2 coarse pulse" : "R1 fine pulse");
            reg_read(A_LVL, rd); check(rd, 0, "R1 level settled");
            reg_write(A_MASK, {24'h0, msk});
            check({31'b0, irq}, {31'b0, |(exp_stat & msk & 8'hC7)}, "R8 random mask");
        end

        // R6/R7 random software set and clear
        reg_write(A_CLR, 32'hFF);
        exp_stat = 8'h00;
        for (int t = 0; t < 20; t++) begin
            logic [7:0] s = $urandom;
            logic [7:0] c = $urandom;
            reg_write(A_STAT, {24'hFFFF_FF, s});
            exp_stat = (exp_stat | s) & 8'hC7;
            reg_read(A_STAT, rd); check(rd, {24'h0, exp_stat}, "R6 software set");
            reg_write(A_CLR, {24'h0, c});
            exp_stat = exp_stat & ~c;
            reg_read(A_STAT, rd); check(rd, {24'h0, exp_stat}, "R7 software clear");
        end

        // R5/R7 core edge in same cycle as clear: set wins
        reg_write(A_CLR, 32'hFF);
        @(negedge clk);
        core_irq = 1'b1; wr = 1'b1; addr = A_CLR; wdata = 32'h1;
        @(negedge clk);
        wr = 1'b0;
        reg_read(A_STAT, rd); check(rd, 32'h01, "R7 set wins over clear");
        reg_write(A_CLR, 32'h1);
        reg_read(A_STAT, rd); check(rd, 0, "R5 level high no re-set");
        core_irq = 1'b0;
        repeat (2) @(negedge clk);
        core_irq = 1'b1;
        @(negedge clk);
        reg_read(A_STAT, rd); check(rd, 32'h01, "R5 core rise");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule